// File: doc/BRIEF.md
# Slot-Scheduled Operand Collector

This block puts a single-ported, wide register array behind a fixed four-cycle schedule. Every clock cycle is one slot of a repeating frame. The first three slots are reads, one for each source operand of an instruction. The fourth slot is a write. Each access moves one whole row of the array: four 64-bit registers, or 256 bits. The block latches each row it reads in staging flops. It then hands the functional unit all three operands on the same cycle, so it works as a serial-to-parallel converter in front of a single-port memory.

An instruction with only two sources leaves its third read slot unused. The block lends that slot to a memory port. A store reads a row through it, and a load writes a row through it. A single-entry result buffer holds the functional unit's output until a write slot is free. Hazard tracking and the functional units themselves live outside this block.

Top module: `rf_collector`

## Requirements
- R1: After a synchronous active-high reset, `frame_slot` is 0, `opnd_valid` and `mem_done` are low, and `result_ready` is high.
- R2: `frame_slot` counts 0, 1, 2, 3 and wraps, advancing by one every cycle. The slot meanings are:
  - 0: read source 1
  - 1: read source 2
  - 2: read source 3, or memory access
  - 3: write
- R3: An instruction is accepted when `issue_valid` is high in a cycle with `frame_slot` = 0. It reads the row of `issue_src1` in slot 0, the row of `issue_src2` in slot 1, and the row of `issue_src3` in slot 2. The three rows appear together on `opnd_a`/`opnd_b`/`opnd_c` with `opnd_valid` high for exactly the slot-3 cycle of that frame. `opnd_valid` is never high in any other slot.
- R4: When the accepted instruction has `issue_use3` low, `opnd_c` is all zeros and slot 2 of that frame is free for the memory port.
- R5: The row is chosen by bits [6:2] of a 7-bit register number. Bits [1:0] do not affect which row is accessed. Register n lies in row n/4.
- R6: A store (`mem_req` high, `mem_load` low) that gets a free slot 2 reads the row of `mem_reg`. That row is on `mem_rdata`, with `mem_done` high for one cycle, in the following slot 3.
- R7: A load (`mem_req` high, `mem_load` high) that gets a free slot 2 writes `mem_wdata` into the row of `mem_reg` in that slot. `mem_done` is then high for one cycle in the following slot 3.
- R8: When slot 2 is taken by a three-source instruction, a pending memory request is not served in that frame (`mem_done` stays low). It is served in the next frame whose slot 2 is free, as long as the requester holds its inputs.
- R9: A result is taken into the buffer on a cycle with `result_valid` and `result_ready` both high. `result_ready` stays low while the buffer is full.
  - The buffered word is written to the row of `result_dst` in the first slot 3 that starts after capture, and the buffer then empties.
  - A read of that row earlier in the same frame returns the old contents.
- R10: The array is never read and written in the same cycle. Writes occur only in slots 2 and 3, and reads only in slots 0 to 2.
- R11: Reset from any slot returns `frame_slot` to 0 on the next cycle. It also discards any buffered result and any accepted instruction, so the discarded result never reaches the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_slot | output | 2 | Current slot of the four-cycle frame |
| issue_valid | input | 1 | Instruction offered; sampled in slot 0 |
| issue_src1 | input | 7 | First source register number |
| issue_src2 | input | 7 | Second source register number |
| issue_src3 | input | 7 | Third source register number |
| issue_use3 | input | 1 | Instruction needs a third source |
| opnd_valid | output | 1 | Operand set valid (slot 3) |
| opnd_a | output | 256 | Row read for source 1 |
| opnd_b | output | 256 | Row read for source 2 |
| opnd_c | output | 256 | Row read for source 3, zero if unused |
| result_valid | input | 1 | Result offered |
| result_dst | input | 7 | Destination register number |
| result_data | input | 256 | Result row |
| result_ready | output | 1 | Result buffer empty |
| mem_req | input | 1 | Memory-side request pending |
| mem_load | input | 1 | 1 = load (array write), 0 = store (array read) |
| mem_reg | input | 7 | Register number of the memory access |
| mem_wdata | input | 256 | Row to write for a load |
| mem_rdata | output | 256 | Row read for a store |
| mem_done | output | 1 | Memory access served; one cycle in slot 3 |

## Verification
The bench builds the block with its default values: 64-bit registers, four lanes per row, and 7-bit register numbers. That gives 32 rows of 256 bits. These values make every row reachable with short preload sequences. With four lanes per row, two low register-number bits are ignored, so indices that differ only in those bits can be shown to alias. The small frame length puts the slot-level collisions within reach of a few directed frames:
- a load contending with a three-source instruction
- a result that arrives too late for its write slot
- a reset asserted mid-frame

// File: rtl/rfc_pkg.sv
`timescale 1ns/1ps
package rfc_pkg;
    parameter int REG_W  = 64;
    parameter int LANES  = 4;
    parameter int IDX_W  = 7;

    typedef enum logic [1:0] {
        SLOT_SRC1 = 2'd0,
        SLOT_SRC2 = 2'd1,
        SLOT_SRC3 = 2'd2,
        SLOT_DST  = 2'd3
    } slot_e;

    function automatic slot_e next_slot(slot_e s);
        return slot_e'(s + 2'd1);
    endfunction
endpackage

// File: rtl/rfc_slot_seq.sv
`timescale 1ns/1ps
module rfc_slot_seq
    import rfc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_e slot
);
    always_ff @(posedge clk) begin
        if (rst) slot <= SLOT_SRC1;
        else     slot <= next_slot(slot);
    end
endmodule

// File: rtl/rfc_sp_array.sv
`timescale 1ns/1ps
module rfc_sp_array #(
    parameter int ROW_W  = 5,
    parameter int WORD_W = 256
) (
    input  logic              clk,
    input  logic              re,
    input  logic              we,
    input  logic [ROW_W-1:0]  addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int ROWS = 1 << ROW_W;

    logic [WORD_W-1:0] store_q [ROWS];

    always_ff @(posedge clk) begin
        if (we) store_q[addr] <= wdata;
    end

    assign rdata = re ? store_q[addr] : '0;
endmodule

// File: rtl/rfc_opnd_stage.sv
`timescale 1ns/1ps
module rfc_opnd_stage
    import rfc_pkg::*;
#(
    parameter int WORD_W = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_e             slot,
    input  logic [WORD_W-1:0] rdata,
    input  logic              take,
    input  logic              ins_v,
    input  logic              use3,
    output logic              opnd_valid,
    output logic [WORD_W-1:0] opnd_a,
    output logic [WORD_W-1:0] opnd_b,
    output logic [WORD_W-1:0] opnd_c
);
    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_valid <= 1'b0;
            opnd_a     <= '0;
            opnd_b     <= '0;
            opnd_c     <= '0;
        end else begin
            opnd_valid <= 1'b0;
            unique case (slot)
                SLOT_SRC1: if (take)  opnd_a <= rdata;
                SLOT_SRC2: if (ins_v) opnd_b <= rdata;
                SLOT_SRC3: begin
                    opnd_c     <= (ins_v && use3) ? rdata : '0;
                    opnd_valid <= ins_v;
                end
                default: ;
            endcase
        end
    end

    // R3
    opnd_slot_chk: assert property (@(posedge clk) disable iff (rst)
        opnd_valid |-> (slot == SLOT_DST));
endmodule

// File: rtl/rf_collector.sv
`timescale 1ns/1ps
module rf_collector
    import rfc_pkg::*;
#(
    parameter int P_REG_W = rfc_pkg::REG_W,
    parameter int P_LANES = rfc_pkg::LANES,
    parameter int P_IDX_W = rfc_pkg::IDX_W
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic [1:0]                 frame_slot,
    input  logic                       issue_valid,
    input  logic [P_IDX_W-1:0]         issue_src1,
    input  logic [P_IDX_W-1:0]         issue_src2,
    input  logic [P_IDX_W-1:0]         issue_src3,
    input  logic                       issue_use3,
    output logic                       opnd_valid,
    output logic [P_REG_W*P_LANES-1:0] opnd_a,
    output logic [P_REG_W*P_LANES-1:0] opnd_b,
    output logic [P_REG_W*P_LANES-1:0] opnd_c,
    input  logic                       result_valid,
    input  logic [P_IDX_W-1:0]         result_dst,
    input  logic [P_REG_W*P_LANES-1:0] result_data,
    output logic                       result_ready,
    input  logic                       mem_req,
    input  logic                       mem_load,
    input  logic [P_IDX_W-1:0]         mem_reg,
    input  logic [P_REG_W*P_LANES-1:0] mem_wdata,
    output logic [P_REG_W*P_LANES-1:0] mem_rdata,
    output logic                       mem_done
);
    localparam int LSEL_W = $clog2(P_LANES);
    localparam int ROW_W  = P_IDX_W - LSEL_W;
    localparam int WORD_W = P_REG_W * P_LANES;

    slot_e slot;
    rfc_slot_seq u_seq (.clk(clk), .rst(rst), .slot(slot));
    assign frame_slot = slot;

    // Lane-select bits play no part in row addressing.
    logic unused_lane_bits;
    assign unused_lane_bits = ^{issue_src1[LSEL_W-1:0], issue_src2[LSEL_W-1:0],
                                issue_src3[LSEL_W-1:0], result_dst[LSEL_W-1:0],
                                mem_reg[LSEL_W-1:0]};

    // Accepted instruction
    logic             take;
    logic             ins_v, ins_use3;
    logic [ROW_W-1:0] ins_src2, ins_src3;
    assign take = (slot == SLOT_SRC1) && issue_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_v    <= 1'b0;
            ins_use3 <= 1'b0;
            ins_src2 <= '0;
            ins_src3 <= '0;
        end else if (slot == SLOT_SRC1) begin
            ins_v    <= issue_valid;
            ins_use3 <= issue_use3;
            ins_src2 <= issue_src2[P_IDX_W-1:LSEL_W];
            ins_src3 <= issue_src3[P_IDX_W-1:LSEL_W];
        end
    end

    // Result buffer
    logic              wb_full;
    logic [ROW_W-1:0]  wb_row;
    logic [WORD_W-1:0] wb_data;
    assign result_ready = !wb_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_full <= 1'b0;
            wb_row  <= '0;
            wb_data <= '0;
        end else if (result_valid && !wb_full) begin
            wb_full <= 1'b1;
            wb_row  <= result_dst[P_IDX_W-1:LSEL_W];
            wb_data <= result_data;
        end else if (slot == SLOT_DST && wb_full) begin
            wb_full <= 1'b0;
        end
    end

    // Slot schedule onto the single array port
    logic              slot3_busy, mem_gnt;
    logic              arr_re, arr_we;
    logic [ROW_W-1:0]  arr_addr;
    logic [WORD_W-1:0] arr_wdata, arr_rdata;

    assign slot3_busy = ins_v && ins_use3;
    assign mem_gnt    = (slot == SLOT_SRC3) && !slot3_busy && mem_req;

    always_comb begin
        arr_re    = 1'b0;
        arr_we    = 1'b0;
        arr_addr  = '0;
        arr_wdata = wb_data;
        unique case (slot)
            SLOT_SRC1: begin
                arr_re   = issue_valid;
                arr_addr = issue_src1[P_IDX_W-1:LSEL_W];
            end
            SLOT_SRC2: begin
                arr_re   = ins_v;
                arr_addr = ins_src2;
            end
            SLOT_SRC3: begin
                if (slot3_busy) begin
                    arr_re   = 1'b1;
                    arr_addr = ins_src3;
                end else if (mem_req) begin
                    arr_re    = !mem_load;
                    arr_we    = mem_load;
                    arr_addr  = mem_reg[P_IDX_W-1:LSEL_W];
                    arr_wdata = mem_wdata;
                end
            end
            SLOT_DST: begin
                arr_we   = wb_full;
                arr_addr = wb_row;
            end
            default: ;
        endcase
    end

    rfc_sp_array #(.ROW_W(ROW_W), .WORD_W(WORD_W)) u_arr (
        .clk(clk), .re(arr_re), .we(arr_we), .addr(arr_addr),
        .wdata(arr_wdata), .rdata(arr_rdata)
    );

    rfc_opnd_stage #(.WORD_W(WORD_W)) u_stage (
        .clk(clk), .rst(rst), .slot(slot), .rdata(arr_rdata),
        .take(take), .ins_v(ins_v), .use3(ins_use3),
        .opnd_valid(opnd_valid), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c)
    );

    // Memory-side completion
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_done  <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_done <= mem_gnt;
            if (mem_gnt && !mem_load) mem_rdata <= arr_rdata;
        end
    end

    // R10
    no_rw_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(arr_re && arr_we));
    // R10
    write_slot_chk: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (slot == SLOT_SRC3 || slot == SLOT_DST));
    // R10
    read_slot_chk: assert property (@(posedge clk) disable iff (rst)
        arr_re |-> (slot != SLOT_DST));
    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (slot != SLOT_DST) |=> (slot == next_slot($past(slot))));
    // R6
    mem_done_slot_chk: assert property (@(posedge clk) disable iff (rst)
        mem_done |-> (slot == SLOT_DST));
    // R9
    buffer_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_DST && !result_ready) |=> result_ready);
endmodule

// File: tb/rf_collector_test.sv
`timescale 1ns/1ps
module rf_collector_test;
    localparam int IDX_W  = 7;
    localparam int WORD_W = 256;
    localparam int ROWS   = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst;
    logic [1:0]        frame_slot;
    logic              issue_valid, issue_use3;
    logic [IDX_W-1:0]  issue_src1, issue_src2, issue_src3;
    logic              opnd_valid;
    logic [WORD_W-1:0] opnd_a, opnd_b, opnd_c;
    logic              result_valid, result_ready;
    logic [IDX_W-1:0]  result_dst;
    logic [WORD_W-1:0] result_data;
    logic              mem_req, mem_load, mem_done;
    logic [IDX_W-1:0]  mem_reg;
    logic [WORD_W-1:0] mem_wdata, mem_rdata;

    rf_collector uut (
        .clk(clk), .rst(rst), .frame_slot(frame_slot),
        .issue_valid(issue_valid), .issue_src1(issue_src1), .issue_src2(issue_src2),
        .issue_src3(issue_src3), .issue_use3(issue_use3),
        .opnd_valid(opnd_valid), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .result_valid(result_valid), .result_dst(result_dst), .result_data(result_data),
        .result_ready(result_ready),
        .mem_req(mem_req), .mem_load(mem_load), .mem_reg(mem_reg),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
    );

    logic [WORD_W-1:0] ref_m [ROWS];
    int vec_n  = 0;
    int miss_n = 0;

    function automatic logic [WORD_W-1:0] pat(int k);
        logic [WORD_W-1:0] w;
        for (int i = 0; i < WORD_W / 32; i++)
            w[i*32 +: 32] = 32'(k) * 32'h9e3779b9 ^ 32'(i * 32'h01010101 + k);
        return w;
    endfunction

    task automatic chk(string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
        vec_n++;
        if (act !== exp) begin
            miss_n++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic to_slot(int s);
        @(negedge clk);
        while (frame_slot != 2'(s)) @(negedge clk);
    endtask

    task automatic do_load(logic [IDX_W-1:0] r, logic [WORD_W-1:0] d);
        to_slot(0);
        mem_req = 1; mem_load = 1; mem_reg = r; mem_wdata = d;
        @(negedge clk);
        while (!mem_done) @(negedge clk);
        chk("R7 done in slot 3", WORD_W'(frame_slot), WORD_W'(3));
        mem_req = 0;
        ref_m[r >> 2] = d;
    endtask

    task automatic run_instr(logic [IDX_W-1:0] s1, s2, s3, logic u3, string req);
        to_slot(0);
        issue_valid = 1; issue_src1 = s1; issue_src2 = s2; issue_src3 = s3; issue_use3 = u3;
        @(negedge clk);
        issue_valid = 0;
        @(negedge clk);
        @(negedge clk);
        chk({req, " opnd_valid"}, WORD_W'(opnd_valid), WORD_W'(1));
        chk({req, " opnd_a"}, opnd_a, ref_m[s1 >> 2]);
        chk({req, " opnd_b"}, opnd_b, ref_m[s2 >> 2]);
        chk({req, " opnd_c"}, opnd_c, u3 ? ref_m[s3 >> 2] : '0);
    endtask

    task automatic t_reset;
        chk("R1 slot", WORD_W'(frame_slot), WORD_W'(0));
        chk("R1 opnd_valid", WORD_W'(opnd_valid), WORD_W'(0));
        chk("R1 mem_done", WORD_W'(mem_done), WORD_W'(0));
        chk("R1 result_ready", WORD_W'(result_ready), WORD_W'(1));
        for (int i = 1; i < 9; i++) begin
            @(negedge clk);
            chk("R2 slot order", WORD_W'(frame_slot), WORD_W'(i % 4));
            if (frame_slot != 2'd3)
                chk("R3 opnd_valid only in slot 3", WORD_W'(opnd_valid), WORD_W'(0));
        end
    endtask

    task automatic t_preload;
        for (int r = 0; r < 8; r++) do_load(7'(r * 4), pat(r + 1));
    endtask

    task automatic t_three_src;
        run_instr(7'd4, 7'd9, 7'd14, 1'b1, "R3 rows 1,2,3");
        run_instr(7'd0, 7'd28, 7'd3, 1'b1, "R3 rows 0,7,0");
    endtask

    task automatic t_two_src_store;
        // Store shares the frame of a two-source instruction
        to_slot(0);
        issue_valid = 1; issue_src1 = 7'd20; issue_src2 = 7'd24; issue_use3 = 0; issue_src3 = 7'd8;
        mem_req = 1; mem_load = 0; mem_reg = 7'd8;
        @(negedge clk); issue_valid = 0;
        @(negedge clk); @(negedge clk);
        chk("R4 opnd_c zero", opnd_c, '0);
        chk("R4 opnd_a", opnd_a, ref_m[5]);
        chk("R6 mem_done", WORD_W'(mem_done), WORD_W'(1));
        chk("R6 mem_rdata", mem_rdata, ref_m[2]);
        mem_req = 0;
    endtask

    task automatic t_lane_alias;
        run_instr(7'd11, 7'd8, 7'd10, 1'b1, "R5 low bits ignored");
    endtask

    task automatic t_wait_slot;
        // Load contends with a three-source instruction
        to_slot(0);
        issue_valid = 1; issue_src1 = 7'd0; issue_src2 = 7'd4; issue_src3 = 7'd36; issue_use3 = 1;
        mem_req = 1; mem_load = 1; mem_reg = 7'd36; mem_wdata = pat(77);
        @(negedge clk); issue_valid = 0;
        @(negedge clk); @(negedge clk);
        chk("R8 no done while slot 2 busy", WORD_W'(mem_done), WORD_W'(0));
        chk("R8 third operand is old row", opnd_c, ref_m[9]);
        repeat (4) @(negedge clk);
        chk("R8 done next frame", WORD_W'(mem_done), WORD_W'(1));
        mem_req = 0;
        ref_m[9] = pat(77);
        run_instr(7'd36, 7'd36, 7'd0, 1'b0, "R8 load landed");
    endtask

    task automatic t_result;
        // Result captured in slot 0, read in same frame sees old data
        to_slot(0);
        result_valid = 1; result_dst = 7'd21; result_data = pat(55);
        issue_valid = 1; issue_src1 = 7'd20; issue_src2 = 7'd4; issue_use3 = 0;
        @(negedge clk);
        result_valid = 0; issue_valid = 0;
        chk("R9 ready low while held", WORD_W'(result_ready), WORD_W'(0));
        @(negedge clk); @(negedge clk);
        chk("R9 same-frame read old", opnd_a, ref_m[5]);
        @(negedge clk);
        chk("R9 ready after write slot", WORD_W'(result_ready), WORD_W'(1));
        ref_m[5] = pat(55);
        run_instr(7'd20, 7'd0, 7'd0, 1'b0, "R9 result visible");
        // Result arriving in slot 3 misses that write slot
        to_slot(3);
        result_valid = 1; result_dst = 7'd24; result_data = pat(66);
        @(negedge clk);
        result_valid = 0;
        issue_valid = 1; issue_src1 = 7'd24; issue_src2 = 7'd0; issue_use3 = 0;
        @(negedge clk); issue_valid = 0;
        @(negedge clk); @(negedge clk);
        chk("R9 late result not yet written", opnd_a, ref_m[6]);
        ref_m[6] = pat(66);
        run_instr(7'd24, 7'd0, 7'd0, 1'b0, "R9 late result written next frame");
    endtask

    task automatic t_reset_mid;
        to_slot(0);
        result_valid = 1; result_dst = 7'd28; result_data = pat(99);
        @(negedge clk);
        result_valid = 0;
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R11 slot back to 0", WORD_W'(frame_slot), WORD_W'(0));
        chk("R11 buffer discarded", WORD_W'(result_ready), WORD_W'(1));
        chk("R11 no operands", WORD_W'(opnd_valid), WORD_W'(0));
        repeat (5) @(negedge clk);
        run_instr(7'd28, 7'd0, 7'd0, 1'b0, "R11 discarded result not written");
    endtask

    initial begin
        rst = 1; issue_valid = 0; issue_use3 = 0;
        issue_src1 = '0; issue_src2 = '0; issue_src3 = '0;
        result_valid = 0; result_dst = '0; result_data = '0;
        mem_req = 0; mem_load = 0; mem_reg = '0; mem_wdata = '0;
        for (int r = 0; r < ROWS; r++) ref_m[r] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_preload();
        t_three_src();
        t_two_src_store();
        t_lane_alias();
        t_wait_slot();
        t_result();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        vec_n++;
        miss_n++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
        $finish;
    end
endmodule